// File: doc/BRIEF.md
# Sequence-Implication Assertion Monitor

This block is a hardware checker for an implication between two ordered Boolean sequences. Each cycle the surrounding logic presents two condition vectors. Bit k of `ant_bits` is the k-th item of the antecedent sequence, and bit k of `con_bits` is the k-th item of the consequent sequence. A one-cycle `arm` strobe starts an attempt. The monitor then walks the antecedent one item per cycle with an index. If every antecedent item holds, it walks the consequent the same way. If a consequent item fails, the implication is reported false.

A three-bit status code shows where the attempt stands in every cycle. A sticky error flag records that any attempt was found false. Sequence lengths are compile-time parameters. Only one attempt runs at a time.

Top module: `seq_impl_monitor`

## Requirements
- R1: Status codes are 0 idle (not started), 1 started, 2 evaluating, 3 false and 4 true, and no other value appears. During reset and in the first cycle after it, status is 0 and `err_sticky` is 0.
- R2: Without an `arm` pulse, status stays 0 whatever the condition vectors hold.
- R3: When `arm` is sampled high at clock edge 0 by an idle monitor, antecedent item k is read from `ant_bits[k]` at edge k+1, one item per edge.
- R4: A zero antecedent item ends the attempt silently. Status stays 0 and `err_sticky` is unchanged.
- R5: When the last antecedent item (edge ANT_LEN) is one, status becomes 1 for one cycle. Consequent item 0 is read from `con_bits[0]` at the next edge.
- R6: Consequent item m is read at edge ANT_LEN+1+m. A one on any item except the last gives status 2.
- R7: A zero consequent item gives status 3 for one cycle, and `err_sticky` rises at that same edge.
- R8: When every consequent item is one, status is 4 for one cycle after the last item is read.
- R9: After a status of 3 or 4, status returns to 0 at the next edge.
- R10: `err_sticky` stays set through later passing attempts until reset clears it.
- R11: An `arm` pulse that arrives while an attempt is still reading items has no effect on the status trace.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| arm | input | 1 | One-cycle strobe that starts an attempt when idle |
| ant_bits | input | ANT_LEN | Antecedent item values, bit k is item k |
| con_bits | input | CON_LEN | Consequent item values, bit m is item m |
| status | output | 3 | Property status code |
| err_sticky | output | 1 | Set when any attempt is false, cleared by reset |

## Verification
The bench builds the monitor with a two-item antecedent and a three-item consequent. At that size every pair of antecedent and consequent patterns can be swept: 32 attempts covering each failure position and the passing case. The expected status for each cycle after the arm edge is computed from the index of the first zero bit in each vector. Busy-time arm pulses and sticky-flag persistence across reset are then checked against that same per-cycle model.

// File: rtl/seqmon_pkg.sv
package seqmon_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_STARTED = 3'd1,
        ST_EVAL    = 3'd2,
        ST_FALSE   = 3'd3,
        ST_TRUE    = 3'd4
    } prop_status_e;

    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_FAIL = 2'd1,
        STEP_MORE = 2'd2,
        STEP_DONE = 2'd3
    } step_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ANT  = 2'd1,
        PH_CON  = 2'd2
    } phase_e;

endpackage

// File: rtl/seqmon_stepper.sv
module seqmon_stepper
    import seqmon_pkg::*;
#(
    parameter int LEN = 2,
    localparam int IW = (LEN > 1) ? $clog2(LEN) : 1
) (
    input  logic            active,
    input  logic [LEN-1:0]  items,
    input  logic [IW-1:0]   idx,
    output step_e           outcome,
    output logic [IW-1:0]   idx_next
);

    localparam logic [IW-1:0] LAST = IW'(LEN - 1);

    always_comb begin
        outcome  = STEP_HOLD;
        idx_next = idx;
        if (active) begin
            if (!items[idx]) begin
                outcome  = STEP_FAIL;
                idx_next = '0;
            end else if (idx == LAST) begin
                outcome  = STEP_DONE;
                idx_next = '0;
            end else begin
                outcome  = STEP_MORE;
                idx_next = idx + 1'b1;
            end
        end
    end

endmodule

// File: rtl/seq_impl_monitor.sv
module seq_impl_monitor
    import seqmon_pkg::*;
#(
    parameter int ANT_LEN = 2,
    parameter int CON_LEN = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               arm,
    input  logic [ANT_LEN-1:0] ant_bits,
    input  logic [CON_LEN-1:0] con_bits,
    output logic [2:0]         status,
    output logic               err_sticky
);

    localparam int AIW = (ANT_LEN > 1) ? $clog2(ANT_LEN) : 1;
    localparam int CIW = (CON_LEN > 1) ? $clog2(CON_LEN) : 1;

    typedef struct packed {
        phase_e        phase;
        logic [AIW-1:0] aidx;
        logic [CIW-1:0] cidx;
        prop_status_e  status;
        logic          err;
    } mon_t;

    mon_t mon_d, mon_q;

    step_e          ant_step, con_step;
    logic [AIW-1:0] ant_nidx;
    logic [CIW-1:0] con_nidx;

    seqmon_stepper #(.LEN(ANT_LEN)) u_ant (
        .active   (mon_q.phase == PH_ANT),
        .items    (ant_bits),
        .idx      (mon_q.aidx),
        .outcome  (ant_step),
        .idx_next (ant_nidx)
    );

    seqmon_stepper #(.LEN(CON_LEN)) u_con (
        .active   (mon_q.phase == PH_CON),
        .items    (con_bits),
        .idx      (mon_q.cidx),
        .outcome  (con_step),
        .idx_next (con_nidx)
    );

    always_comb begin
        mon_d = mon_q;
        case (mon_q.phase)
            PH_IDLE: begin
                mon_d.status = ST_IDLE;
                if (arm) begin
                    mon_d.phase = PH_ANT;
                    mon_d.aidx  = '0;
                end
            end
            PH_ANT: begin
                mon_d.aidx = ant_nidx;
                case (ant_step)
                    STEP_FAIL: begin
                        mon_d.phase  = PH_IDLE;
                        mon_d.status = ST_IDLE;
                    end
                    STEP_DONE: begin
                        mon_d.phase  = PH_CON;
                        mon_d.cidx   = '0;
                        mon_d.status = ST_STARTED;
                    end
                    default: mon_d.status = ST_IDLE;
                endcase
            end
            PH_CON: begin
                mon_d.cidx = con_nidx;
                case (con_step)
                    STEP_FAIL: begin
                        mon_d.phase  = PH_IDLE;
                        mon_d.status = ST_FALSE;
                        mon_d.err    = 1'b1;
                    end
                    STEP_DONE: begin
                        mon_d.phase  = PH_IDLE;
                        mon_d.status = ST_TRUE;
                    end
                    default: mon_d.status = ST_EVAL;
                endcase
            end
            default: begin
                mon_d.phase  = PH_IDLE;
                mon_d.status = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mon_q <= '{phase: PH_IDLE, aidx: '0, cidx: '0,
                       status: ST_IDLE, err: 1'b0};
        end else begin
            mon_q <= mon_d;
        end
    end

    assign status     = mon_q.status;
    assign err_sticky = mon_q.err;

endmodule

// File: rtl/seqmon_checker.sv
module seqmon_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       arm,
    input logic [2:0] status,
    input logic       err_sticky
);

    AST_STATUS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        status <= 3'd4); // R1

    AST_IDLE_STAYS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        status == 3'd0 |=> (status == 3'd0 || status == 3'd1)); // R2

    AST_STARTED_MOVES_ON: assert property (@(posedge clk) disable iff (!rst_n)
        status == 3'd1 |=> (status >= 3'd2)); // R5

    AST_EVAL_MOVES_ON: assert property (@(posedge clk) disable iff (!rst_n)
        status == 3'd2 |=> (status >= 3'd2)); // R6

    AST_FALSE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        status == 3'd3 |-> err_sticky); // R7

    AST_ERR_RISE_ON_FALSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_sticky) |-> status == 3'd3); // R7

    AST_RESULT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 3'd3 || status == 3'd4) |=> status == 3'd0); // R9

    AST_ERR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        err_sticky |=> err_sticky); // R10

    logic unused_arm;
    assign unused_arm = arm;

endmodule

bind seq_impl_monitor seqmon_checker u_seqmon_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .arm        (arm),
    .status     (status),
    .err_sticky (err_sticky)
);

// File: tb/seq_impl_monitor_test.sv
module seq_impl_monitor_test;

    localparam int AL = 2;
    localparam int CL = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          arm = 1'b0;
    logic [AL-1:0] ant = '0;
    logic [CL-1:0] con = '0;
    logic [2:0]    status;
    logic          err;

    int total = 0;
    int bad = 0;
    bit err_model = 1'b0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    seq_impl_monitor #(.ANT_LEN(AL), .CON_LEN(CL)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .arm        (arm),
        .ant_bits   (ant),
        .con_bits   (con),
        .status     (status),
        .err_sticky (err)
    );

    task automatic chk(input logic [2:0] exp_s, input logic exp_e, input string req);
        total++;
        if (status !== exp_s || err !== exp_e) begin
            bad++;
            $display("FAIL %s: status=%0d err=%0d expected status=%0d err=%0d",
                     req, status, err, exp_s, exp_e);
        end
    endtask

    function automatic int first_zero(input logic [31:0] v, input int n);
        for (int i = 0; i < n; i++) if (!v[i]) return i;
        return n;
    endfunction

    // Expected status after edge k, edge 0 being the one that samples arm
    function automatic logic [2:0] exp_status(input int k, input int fa, input int fc);
        int m;
        if (fa < AL) return 3'd0;
        if (k < AL) return 3'd0;
        if (k == AL) return 3'd1;
        m = k - AL - 1;
        if (fc < CL) begin
            if (m < fc) return 3'd2;
            if (m == fc) return 3'd3;
            return 3'd0;
        end
        if (m < CL - 1) return 3'd2;
        if (m == CL - 1) return 3'd4;
        return 3'd0;
    endfunction

    function automatic string req_of(input logic [2:0] e, input int k, input int fa);
        case (e)
            3'd1: return "R5";
            3'd2: return "R6";
            3'd3: return "R7";
            3'd4: return "R8";
            default: return (fa < AL) ? "R4" : ((k > AL) ? "R9" : "R3");
        endcase
    endfunction

    task automatic run_trial(input int a, input int c, input int busy_at, input string base);
        int fa;
        int fc;
        logic [2:0] e;
        fa = first_zero(32'(a), AL);
        fc = first_zero(32'(c), CL);
        @(negedge clk);
        ant = AL'(a);
        con = CL'(c);
        arm = 1'b1;
        @(negedge clk);
        arm = 1'b0;
        for (int k = 0; k <= AL + CL + 2; k++) begin
            e = exp_status(k, fa, fc);
            if (e == 3'd3) err_model = 1'b1;
            chk(e, err_model, $sformatf("%s/%s a=%0d c=%0d k=%0d",
                base, req_of(e, k, fa), a, c, k));
            arm = (k == busy_at);
            @(negedge clk);
        end
        arm = 1'b0;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(8 * 100000);
        total++;
        bad++;
        $display("FAIL watchdog: run did not complete, expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(3'd0, 1'b0, "R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk(3'd0, 1'b0, "R1 after reset");

        // no arm: all items true, nothing must start
        ant = '1;
        con = '1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk(3'd0, 1'b0, "R2 unarmed");
        end

        // exhaustive sweep of antecedent and consequent patterns
        for (int a = 0; a < (1 << AL); a++)
            for (int c = 0; c < (1 << CL); c++)
                run_trial(a, c, -1, "R3");

        // arm pulses during a busy attempt
        run_trial((1 << AL) - 1, (1 << CL) - 1, 0, "R11");
        run_trial((1 << AL) - 1, (1 << CL) - 1, 1, "R11");
        run_trial((1 << AL) - 1, (1 << CL) - 1, 3, "R11");
        run_trial((1 << AL) - 1, 2, 2, "R11");

        // sticky flag survives a clean attempt
        run_trial((1 << AL) - 1, (1 << CL) - 1, -1, "R10");
        @(negedge clk);
        chk(3'd0, 1'b1, "R10 still set");

        // reset clears the sticky flag
        rst_n = 1'b0;
        err_model = 1'b0;
        @(negedge clk);
        chk(3'd0, 1'b0, "R10 cleared by reset");
        rst_n = 1'b1;
        run_trial((1 << AL) - 1, (1 << CL) - 1, -1, "R8");

        summary();
    end

endmodule